// File: doc/BRIEF.md
# Serial interrupt frame driver

This block is the peripheral side of a shared, single-wire, clocked interrupt line. A start pulse may come from the host or from any agent. The block waits for the pulse's rising edge and then counts fixed three-clock frames. Each frame belongs to one interrupt slot. In a slot whose request is asserted, the block pulls the line low in the first clock of the frame, drives it high in the second clock, and releases it in the third. A slot with no request stays released for the whole frame.

The line is shown as an input value, an output value and an output enable, so pad logic can build an open-drain style buffer. Request inputs are active low and go through a synchronizer. They are captured once per cycle, at the start pulse's rising edge. One slot can carry either a management interrupt or a normal request, picked by a static select input.

After the last frame the host sends a stop pulse, and its low time sets the mode for the next cycle. In quiet mode the block may start a cycle by itself when a request has changed. In continuous mode it waits for the host.

Top module: `serint_agent`

## Requirements
- R1: Clock 0 is the first clock on which the line reads high after a start pulse. The block leaves the line released on clock 1. Frame n (n = 1..16) occupies clocks 3n-1, 3n and 3n+1 as the sample, recovery and turn-around clocks. The last turn-around is clock 49.
- R2: On a sample clock the block drives the line low (`line_oe`=1, `line_o`=0) exactly when that slot's captured value is 0. Otherwise `line_oe` is 0.
- R3: On a recovery clock the block drives high (`line_oe`=1, `line_o`=1) only if it drove low on the sample clock just before. On every turn-around clock `line_oe` is 0.
- R4: Bit k of `req_n` feeds frame k+1. When `mgmt_sel` is 1, frame 3 carries `mgmt_req_n` in place of `req_n[2]`. Frame 14 carries `req_n[13]`.
- R5: Requests pass through a two-stage synchronizer and are captured at the end of clock 0. A request that changes later in the cycle does not change any frame of that cycle.
- R6: A stop pulse is the low time seen after the last frame. Two low clocks select quiet mode and three select continuous mode. Any other length leaves the mode as it was.
- R7: In quiet mode, if a synchronized slot value differs from the value last captured, the block drives the line low for exactly one clock and then releases it. The earliest such clock is clock 2 after the stop pulse's rising edge. With no difference it does not start a cycle.
- R8: In continuous mode the block never drives the line outside the frames.
- R9: After reset the line is released and the mode is continuous.
- R10: Frames are driven the same way whether the host or this block began the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | NUM_SLOTS | Active-low interrupt requests; bit k feeds frame k+1 |
| mgmt_req_n | input | 1 | Active-low management interrupt |
| mgmt_sel | input | 1 | 1: the management interrupt replaces bit MGMT_SLOT of `req_n` |
| line_i | input | 1 | Level read from the shared line |
| line_o | output | 1 | Level driven when enabled |
| line_oe | output | 1 | Drive enable; 0 leaves the line released |

## Verification
The bench builds the block with its default parameters: 16 slots, two synchronizer stages, the management interrupt on slot index 2, and stop lengths of 2 and 3. With these values every one of the 16 frame positions is checked clock by clock, up to the turn-around on clock 49, and both settings of the frame 3 source are covered. The synchronizer delay places the earliest self-started pulse exactly on clock 2 after the stop edge, and the bench checks that clock. Stop lengths of 1 and 4 lie outside both legal values, so the bench uses them to show that the mode is kept.

// File: rtl/serint_pkg.sv
package serint_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SELF,
      ST_START,
      ST_LEAD,
      ST_FRAMES,
      ST_STOPW,
      ST_STOPL,
      ST_HOLD
   } serint_st_t;

   typedef enum logic [1:0] {
      PH_SAMPLE,
      PH_RECOV,
      PH_TURN
   } serint_ph_t;

endpackage

// File: rtl/serint_sync.sv
module serint_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{RST_VAL}};
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/serint_slot_map.sv
module serint_slot_map #(
   parameter int NUM_SLOTS = 16,
   parameter int MGMT_SLOT = 2
) (
   input  logic [NUM_SLOTS-1:0] req_n,
   input  logic                 mgmt_n,
   input  logic                 mgmt_sel,
   output logic [NUM_SLOTS-1:0] slot_n
);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      if (i == MGMT_SLOT) begin : g_shared
         assign slot_n[i] = mgmt_sel ? mgmt_n : req_n[i];
      end else begin : g_direct
         assign slot_n[i] = req_n[i];
      end
   end

endmodule

// File: rtl/serint_frame_fsm.sv
module serint_frame_fsm
   import serint_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int QUIET_LEN = 2,
   parameter int CONT_LEN  = 3,
   localparam int FRAME_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int MAX_LEN  = (QUIET_LEN > CONT_LEN) ? QUIET_LEN : CONT_LEN,
   localparam int LOW_W    = $clog2(MAX_LEN + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_i,
   input  logic [NUM_SLOTS-1:0] slot_now,
   output serint_st_t           st,
   output serint_ph_t           phase,
   output logic [FRAME_W-1:0]   frame,
   output logic [NUM_SLOTS-1:0] latched,
   output logic                 quiet
);

   localparam logic [LOW_W-1:0]   LOW_SAT   = {LOW_W{1'b1}};
   localparam logic [LOW_W-1:0]   LEN_QUIET = LOW_W'(QUIET_LEN);
   localparam logic [LOW_W-1:0]   LEN_CONT  = LOW_W'(CONT_LEN);
   localparam logic [FRAME_W-1:0] LAST_FR   = FRAME_W'(NUM_SLOTS - 1);

   logic [LOW_W-1:0] low_cnt;
   logic             pending;

   assign pending = |(slot_now ^ latched);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         phase   <= PH_SAMPLE;
         frame   <= '0;
         latched <= '1;
         quiet   <= 1'b0;
         low_cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (!line_i)               st <= ST_START;
               else if (quiet && pending) st <= ST_SELF;
            end
            ST_SELF:  st <= ST_START;
            ST_START: begin
               if (line_i) begin
                  st      <= ST_LEAD;
                  latched <= slot_now;
               end
            end
            ST_LEAD: begin
               st    <= ST_FRAMES;
               phase <= PH_SAMPLE;
               frame <= '0;
            end
            ST_FRAMES: begin
               case (phase)
                  PH_SAMPLE: phase <= PH_RECOV;
                  PH_RECOV:  phase <= PH_TURN;
                  default: begin
                     phase <= PH_SAMPLE;
                     if (frame == LAST_FR) st <= ST_STOPW;
                     else                  frame <= frame + 1'b1;
                  end
               endcase
            end
            ST_STOPW: begin
               if (!line_i) begin
                  st      <= ST_STOPL;
                  low_cnt <= LOW_W'(1);
               end
            end
            ST_STOPL: begin
               if (!line_i) begin
                  if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
               end else begin
                  if (low_cnt == LEN_QUIET)     quiet <= 1'b1;
                  else if (low_cnt == LEN_CONT) quiet <= 1'b0;
                  st <= ST_HOLD;
               end
            end
            ST_HOLD: st <= (quiet && pending) ? ST_SELF : ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serint_line_drv.sv
module serint_line_drv
   import serint_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   localparam int FRAME_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  serint_st_t           st,
   input  serint_ph_t           phase,
   input  logic [FRAME_W-1:0]   frame,
   input  logic [NUM_SLOTS-1:0] latched,
   output logic                 oe,
   output logic                 o
);

   logic cur_low;
   logic drove_low;

   assign cur_low = ~latched[frame];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drove_low <= 1'b0;
      else        drove_low <= (st == ST_FRAMES) && (phase == PH_SAMPLE) && cur_low;
   end

   always_comb begin
      oe = 1'b0;
      o  = 1'b0;
      case (st)
         ST_SELF: oe = 1'b1;
         ST_FRAMES: begin
            case (phase)
               PH_SAMPLE: oe = cur_low;
               PH_RECOV: begin
                  oe = drove_low;
                  o  = 1'b1;
               end
               default: oe = 1'b0;
            endcase
         end
         default: oe = 1'b0;
      endcase
   end

endmodule

// File: rtl/serint_agent.sv
module serint_agent
   import serint_pkg::*;
#(
   parameter int NUM_SLOTS   = 16,
   parameter int SYNC_STAGES = 2,
   parameter int MGMT_SLOT   = 2,
   parameter int QUIET_LEN   = 2,
   parameter int CONT_LEN    = 3,
   localparam int FRAME_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] req_n,
   input  logic                 mgmt_req_n,
   input  logic                 mgmt_sel,
   input  logic                 line_i,
   output logic                 line_o,
   output logic                 line_oe
);

   if (NUM_SLOTS < 2 || NUM_SLOTS > 32) begin : g_bad_slots
      $error("serint_agent: NUM_SLOTS must lie in 2..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("serint_agent: SYNC_STAGES must be at least 2");
   end
   if (MGMT_SLOT < 0 || MGMT_SLOT >= NUM_SLOTS) begin : g_bad_mgmt
      $error("serint_agent: MGMT_SLOT must index an existing slot");
   end
   if (QUIET_LEN < 2 || CONT_LEN < 2 || QUIET_LEN == CONT_LEN) begin : g_bad_stop
      $error("serint_agent: stop lengths must be distinct and at least 2");
   end

   logic [NUM_SLOTS:0]   raw_bus;
   logic [NUM_SLOTS:0]   sync_bus;
   logic [NUM_SLOTS-1:0] slot_now;
   serint_st_t           st;
   serint_ph_t           phase;
   logic [FRAME_W-1:0]   frame_idx;
   logic [NUM_SLOTS-1:0] slot_latched;
   logic                 quiet_mode;

   assign raw_bus = {mgmt_req_n, req_n};

   serint_sync #(
      .WIDTH   (NUM_SLOTS + 1),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_bus),
      .q     (sync_bus)
   );

   serint_slot_map #(
      .NUM_SLOTS (NUM_SLOTS),
      .MGMT_SLOT (MGMT_SLOT)
   ) u_map (
      .req_n    (sync_bus[NUM_SLOTS-1:0]),
      .mgmt_n   (sync_bus[NUM_SLOTS]),
      .mgmt_sel (mgmt_sel),
      .slot_n   (slot_now)
   );

   serint_frame_fsm #(
      .NUM_SLOTS (NUM_SLOTS),
      .QUIET_LEN (QUIET_LEN),
      .CONT_LEN  (CONT_LEN)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_i),
      .slot_now (slot_now),
      .st       (st),
      .phase    (phase),
      .frame    (frame_idx),
      .latched  (slot_latched),
      .quiet    (quiet_mode)
   );

   serint_line_drv #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .st      (st),
      .phase   (phase),
      .frame   (frame_idx),
      .latched (slot_latched),
      .oe      (line_oe),
      .o       (line_o)
   );

endmodule

// File: rtl/serint_agent_chk.sv
module serint_agent_chk
   import serint_pkg::*;
#(
   parameter int NUM_SLOTS = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 line_oe,
   input logic                 line_o,
   input serint_st_t           st,
   input serint_ph_t           phase,
   input logic                 quiet,
   input logic [NUM_SLOTS-1:0] latched
);

   // R3
   recov_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FRAMES && phase == PH_SAMPLE && line_oe) |=> (line_oe && line_o));

   // R3
   turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_oe && line_o) |=> !line_oe);

   // R3
   high_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_oe && line_o) |-> $past(line_oe && !line_o));

   // R1
   drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> (st == ST_FRAMES || st == ST_SELF));

   // R8
   self_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SELF) |-> quiet);

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FRAMES) |=> $stable(latched));

endmodule

bind serint_agent serint_agent_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .line_oe (line_oe),
   .line_o  (line_o),
   .st      (st),
   .phase   (phase),
   .quiet   (quiet_mode),
   .latched (slot_latched)
);

// File: tb/serint_agent_test.sv
module serint_agent_test;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 7;
   // {mgmt_sel, mgmt_req_n, req_n}
   localparam logic [17:0] VECS [NV] = '{
      {1'b0, 1'b1, 16'hFFFF},
      {1'b0, 1'b1, 16'h0000},
      {1'b0, 1'b1, 16'hA5A5},
      {1'b1, 1'b1, 16'hFFFB},
      {1'b1, 1'b0, 16'hFFFF},
      {1'b0, 1'b0, 16'hDFFE},
      {1'b0, 1'b1, 16'h7FFE}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req_n = 16'hFFFF;
   logic        mgmt_req_n = 1'b1;
   logic        mgmt_sel = 1'b0;
   logic        host_drv = 1'b0;
   logic        line_o, line_oe, line;
   int          checks = 0;
   int          fails = 0;

   assign line = line_oe ? line_o : !host_drv;

   always #(CLK_PERIOD / 2) clk = ~clk;

   serint_agent uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_n      (req_n),
      .mgmt_req_n (mgmt_req_n),
      .mgmt_sel   (mgmt_sel),
      .line_i     (line),
      .line_o     (line_o),
      .line_oe    (line_oe)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_slots(input logic [17:0] v);
      logic [15:0] r;
      r = v[15:0];
      if (v[17]) r[2] = v[16];
      return r;
   endfunction

   task automatic host_start(input int len);
      repeat (3) @(negedge clk);
      host_drv = 1'b1;
      repeat (len) @(negedge clk);
      host_drv = 1'b0;
   endtask

   task automatic host_stop(input int len);
      @(negedge clk);
      host_drv = 1'b1;
      repeat (len) @(negedge clk);
      host_drv = 1'b0;
   endtask

   task automatic check_frames(input logic [15:0] e, input string tag,
                               input int chg_at, input logic [15:0] chg_val);
      for (int c = 1; c <= 49; c++) begin
         @(negedge clk);
         if (c == 1) begin
            chk(line_oe == 1'b0, "R1", "clock 1 oe", line_oe, 0);
         end else begin
            int k;
            int ph;
            k  = (c + 1) / 3 - 1;
            ph = (c + 1) % 3;
            if (ph == 0) begin
               chk(line_oe == !e[k] && (!line_oe || line_o == 1'b0), tag,
                   $sformatf("sample frame %0d oe,o", k + 1),
                   {line_oe, line_o}, {!e[k], 1'b0});
            end else if (ph == 1) begin
               chk(line_oe == !e[k] && (!line_oe || line_o == 1'b1), "R3",
                   $sformatf("recovery frame %0d oe,o", k + 1),
                   {line_oe, line_o}, {!e[k], 1'b1});
            end else begin
               chk(line_oe == 1'b0, "R3",
                   $sformatf("turn-around frame %0d oe", k + 1), line_oe, 0);
            end
         end
         if (c == chg_at) req_n = chg_val;
      end
   endtask

   task automatic watch_low(input int n, output int at);
      at = 0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (line_oe && !line_o) begin
            at = i;
            break;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int at;
      // R9: reset state, requests pending but mode is continuous
      req_n = 16'h0000;
      repeat (4) @(negedge clk);
      chk(line_oe == 1'b0, "R9", "oe in reset", line_oe, 0);
      rst_n = 1'b1;
      watch_low(10, at);
      chk(at == 0, "R9", "self start after reset", at, 0);
      req_n = 16'hFFFF;

      // table walk, host starts, continuous stop
      for (int v = 0; v < NV; v++) begin
         req_n      = VECS[v][15:0];
         mgmt_req_n = VECS[v][16];
         mgmt_sel   = VECS[v][17];
         host_start(4);
         check_frames(exp_slots(VECS[v]), VECS[v][17] ? "R4" : "R2", 0, 16'h0);
         host_stop(3);
      end
      mgmt_sel = 1'b0;
      mgmt_req_n = 1'b1;

      // R5: change during frames does not reach this cycle
      req_n = 16'hFFFF;
      host_start(6);
      check_frames(16'hFFFF, "R5", 10, 16'h7FFF);
      // R6: two-clock stop selects quiet; R7: self start on clock 2
      host_stop(2);
      watch_low(6, at);
      chk(at == 2, "R7", "self start clock after stop edge", at, 2);
      @(negedge clk);
      chk(line_oe == 1'b0, "R7", "release after one low clock", line_oe, 0);
      // R10: frames of a self-started cycle
      check_frames(16'h7FFF, "R10", 0, 16'h0);
      host_stop(2);
      watch_low(10, at);
      chk(at == 0, "R7", "no self start without change", at, 0);

      // R6: stop of four keeps quiet mode
      host_start(4);
      check_frames(16'h7FFF, "R2", 0, 16'h0);
      host_stop(4);
      req_n = 16'hFFFF;
      watch_low(10, at);
      chk(at != 0, "R6", "quiet kept after 4-clock stop (start seen)", at, 3);
      @(negedge clk);
      check_frames(16'hFFFF, "R10", 0, 16'h0);

      // R8: continuous mode, change never self-starts
      host_stop(3);
      req_n = 16'h0000;
      watch_low(12, at);
      chk(at == 0, "R8", "self start in continuous", at, 0);

      // R6: stop of one keeps continuous mode
      host_start(4);
      check_frames(16'h0000, "R2", 0, 16'h0);
      host_stop(1);
      req_n = 16'hFFFF;
      watch_low(12, at);
      chk(at == 0, "R6", "continuous kept after 1-clock stop", at, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule